// File: doc/BRIEF.md
# Priority Throttle Arbiter with Pulse Skipper

This block takes several throttle sources and picks one to govern two clocks. Each thermal source compares a temperature reading against its own hot threshold. One over-current source is a plain alarm input. Every source holds a programmed entry with a precedence value, a CPU skip percentage and a GPU throttle level.

On every cycle the block finds the eligible source with the highest precedence and registers its settings. From those settings it produces two clock-enable strobes, one for the CPU clock and one for the GPU clock. The strobes drop a proportion of clock pulses that matches the chosen depth. An accumulator spreads the dropped pulses evenly over time.

Configuration goes through a single write port. That port addresses one entry per write and loads the entry's precedence, CPU depth, GPU level and threshold together.

Top module: `thr_skip_top`

## Requirements
- R1: After reset every entry has precedence 0, `sel_valid_o` is 0, `sel_cpu_pct_o` and `sel_gpu_lvl_o` are 0, and both enables are high on every cycle. This holds even if the over-current alarm is raised.
- R2: When `cfg_we_i` is high at a clock edge, the entry at `cfg_idx_i` is loaded. Thermal entries are indices 0..NTHERM-1 and the over-current entry is index NTHERM. The new contents affect the selection outputs one edge later. A write to an index above NTHERM changes nothing.
- R3: Thermal source t is raised only when the unsigned reading in `temp_i[t*TEMP_W +: TEMP_W]` is strictly greater than its threshold. A reading equal to the threshold does not raise it.
- R4: The over-current source is raised while `oc_alarm_i` is 1 (active high).
- R5: Precedence 0 disables an entry. Written precedence or CPU percentage values above 100 are stored as 100.
- R6: Among the raised, enabled entries, the one with the largest precedence is selected. On the edge after the inputs settle, `sel_valid_o`=1, `sel_idx_o` is its index, and `sel_cpu_pct_o`/`sel_gpu_lvl_o` are its settings.
- R7: When raised entries share the top precedence, the lowest index is selected.
- R8: With no eligible entry, `sel_valid_o`=0, both selected depths read 0, and both enables stay high.
- R9: With a fixed selection, any 100 consecutive cycles of `cpu_clk_en_o` hold exactly 100 minus the CPU percentage high cycles. This gives all high at 0% and all low at 100%.
- R10: GPU level 0, 1, 2 and 3 give 100, 50, 25 and 15 high cycles of `gpu_clk_en_o` per 100 consecutive cycles.
- R11: Skips are spread evenly. At a depth of 50% or less, an enable is never low on two consecutive cycles.
- R12: A change of selection does not clear the accumulators. The new depth governs the enables from the second edge after the request change, with exact counts from that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| temp_i | input | NTHERM*TEMP_W | Packed temperature readings, source 0 in the low bits |
| oc_alarm_i | input | 1 | Over-current alarm, active high |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | IDXW | Entry index for the write |
| cfg_prio_i | input | 7 | Precedence, 0 disables, 1..100 |
| cfg_cpu_pct_i | input | 7 | CPU skip percentage |
| cfg_gpu_lvl_i | input | 2 | GPU throttle level |
| cfg_thr_i | input | TEMP_W | Hot threshold (thermal entries only) |
| sel_valid_o | output | 1 | An entry is selected |
| sel_idx_o | output | IDXW | Index of the selected entry |
| sel_cpu_pct_o | output | 7 | Selected CPU skip percentage |
| sel_gpu_lvl_o | output | 2 | Selected GPU level |
| cpu_clk_en_o | output | 1 | CPU clock-enable strobe |
| gpu_clk_en_o | output | 1 | GPU clock-enable strobe |

## Verification
A fault in the selection state appears on the selection outputs one edge after the inputs change. Examples are a wrong comparison, a lost tie rule, or an unsaturated field. A corrupted accumulator or a wrong pass fraction cannot be seen on a single cycle. It shows up as a wrong count of enable pulses within the first window of 100 cycles after the second edge. It can also show as two back-to-back skips at shallow depths. The directed scenarios therefore sample the selection one edge after each change and count enables over exact 100-cycle windows.

// File: rtl/thr_pkg.sv
package thr_pkg;
    localparam int PCT_W    = 7;
    localparam int LVL_W    = 2;
    localparam int PCT_FULL = 100;

    typedef struct packed {
        logic [PCT_W-1:0] prio;
        logic [PCT_W-1:0] cpu_pct;
        logic [LVL_W-1:0] gpu_lvl;
    } thr_cfg_t;

    // clamp a field to the 0..100 range
    function automatic logic [PCT_W-1:0] sat_pct(input logic [PCT_W-1:0] v);
        return (v > PCT_W'(PCT_FULL)) ? PCT_W'(PCT_FULL) : v;
    endfunction

    // pulses passed per 100 cycles for a CPU skip percentage
    function automatic logic [PCT_W-1:0] cpu_pass(input logic [PCT_W-1:0] pct);
        return PCT_W'(PCT_FULL) - pct;
    endfunction

    // pulses passed per 100 cycles for a GPU level
    function automatic logic [PCT_W-1:0] lvl_pass(input logic [LVL_W-1:0] lvl);
        logic [PCT_W-1:0] p;
        case (lvl)
            2'd0:    p = PCT_W'(100);
            2'd1:    p = PCT_W'(50);
            2'd2:    p = PCT_W'(25);
            default: p = PCT_W'(15);
        endcase
        return p;
    endfunction
endpackage

// File: rtl/thr_cfg_regs.sv
module thr_cfg_regs
    import thr_pkg::*;
#(
    parameter int NREQ   = 3,
    parameter int NTHERM = 2,
    parameter int TEMP_W = 8,
    parameter int IDXW   = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              we_i,
    input  logic [IDXW-1:0]                   idx_i,
    input  logic [PCT_W-1:0]                  prio_i,
    input  logic [PCT_W-1:0]                  pct_i,
    input  logic [LVL_W-1:0]                  lvl_i,
    input  logic [TEMP_W-1:0]                 thr_i,
    output thr_cfg_t [NREQ-1:0]               cfg_o,
    output logic [NTHERM-1:0][TEMP_W-1:0]     thr_o
);
    typedef struct packed {
        thr_cfg_t [NREQ-1:0]               ent;
        logic [NTHERM-1:0][TEMP_W-1:0]     thr;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (we_i) begin
            for (int i = 0; i < NREQ; i++) begin
                if (int'(idx_i) == i) begin
                    regs_d.ent[i].prio    = sat_pct(prio_i);
                    regs_d.ent[i].cpu_pct = sat_pct(pct_i);
                    regs_d.ent[i].gpu_lvl = lvl_i;
                end
            end
            for (int t = 0; t < NTHERM; t++) begin
                if (int'(idx_i) == t) begin
                    regs_d.thr[t] = thr_i;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q.ent <= '0;
            regs_q.thr <= '1;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign cfg_o = regs_q.ent;
    assign thr_o = regs_q.thr;

    for (genvar g = 0; g < NREQ; g++) begin : g_chk
        AST_PRIO_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            regs_q.ent[g].prio <= PCT_W'(PCT_FULL)); // R5
        AST_PCT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            regs_q.ent[g].cpu_pct <= PCT_W'(PCT_FULL)); // R5
    end
endmodule

// File: rtl/thr_req_gen.sv
module thr_req_gen #(
    parameter int NTHERM = 2,
    parameter int TEMP_W = 8,
    parameter int NREQ   = 3
) (
    input  logic [NTHERM*TEMP_W-1:0]      temp_i,
    input  logic [NTHERM-1:0][TEMP_W-1:0] thr_i,
    input  logic                          oc_i,
    output logic [NREQ-1:0]               raised_o
);
    for (genvar t = 0; t < NTHERM; t++) begin : g_therm
        assign raised_o[t] = temp_i[t*TEMP_W +: TEMP_W] > thr_i[t];
    end
    assign raised_o[NREQ-1] = oc_i;
endmodule

// File: rtl/thr_prio_sel.sv
module thr_prio_sel
    import thr_pkg::*;
#(
    parameter int NREQ = 3,
    parameter int IDXW = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NREQ-1:0]      raised_i,
    input  thr_cfg_t [NREQ-1:0]  cfg_i,
    output logic                 sel_valid_o,
    output logic [IDXW-1:0]      sel_idx_o,
    output logic [PCT_W-1:0]     sel_pct_o,
    output logic [LVL_W-1:0]     sel_lvl_o
);
    typedef struct packed {
        logic             valid;
        logic [IDXW-1:0]  idx;
        logic [PCT_W-1:0] pct;
        logic [LVL_W-1:0] lvl;
    } sel_t;

    sel_t             sel_d, sel_q;
    logic [NREQ-1:0]  elig;
    logic             win_valid;
    logic [IDXW-1:0]  win_idx;
    logic [PCT_W-1:0] win_prio;

    always_comb begin
        for (int i = 0; i < NREQ; i++) begin
            elig[i] = raised_i[i] && (cfg_i[i].prio != '0);
        end
    end

    // strict greater-than keeps the lower index on a tie
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        win_prio  = '0;
        for (int i = 0; i < NREQ; i++) begin
            if (elig[i] && (cfg_i[i].prio > win_prio)) begin
                win_valid = 1'b1;
                win_idx   = IDXW'(i);
                win_prio  = cfg_i[i].prio;
            end
        end
    end

    always_comb begin
        sel_d       = '0;
        sel_d.valid = win_valid;
        if (win_valid) begin
            sel_d.idx = win_idx;
            for (int i = 0; i < NREQ; i++) begin
                if (int'(win_idx) == i) begin
                    sel_d.pct = cfg_i[i].cpu_pct;
                    sel_d.lvl = cfg_i[i].gpu_lvl;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= '0;
        else        sel_q <= sel_d;
    end

    assign sel_valid_o = sel_q.valid;
    assign sel_idx_o   = sel_q.idx;
    assign sel_pct_o   = sel_q.pct;
    assign sel_lvl_o   = sel_q.lvl;

    for (genvar j = 0; j < NREQ; j++) begin : g_chk
        AST_WIN_HIGHEST: assert property (@(posedge clk) disable iff (!rst_n)
            (win_valid && elig[j]) |-> (cfg_i[j].prio <= win_prio)); // R6
        AST_TIE_LOW_IDX: assert property (@(posedge clk) disable iff (!rst_n)
            (win_valid && elig[j] && cfg_i[j].prio == win_prio) |-> (int'(win_idx) <= j)); // R7
    end
    AST_NONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (elig == '0) |=> !sel_valid_o); // R8
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_valid_o |-> (sel_pct_o == '0 && sel_lvl_o == '0)); // R8
endmodule

// File: rtl/thr_pulse_skip.sv
module thr_pulse_skip
    import thr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PCT_W-1:0] pass_i,
    output logic             en_o
);
    typedef struct packed {
        logic [PCT_W-1:0] acc;
        logic             en;
    } skip_t;

    skip_t          st_d, st_q;
    logic [PCT_W:0] sum;

    always_comb begin
        sum = {1'b0, st_q.acc} + {1'b0, pass_i};
        if (sum >= (PCT_W+1)'(PCT_FULL)) begin
            st_d.en  = 1'b1;
            st_d.acc = PCT_W'(sum - (PCT_W+1)'(PCT_FULL));
        end else begin
            st_d.en  = 1'b0;
            st_d.acc = PCT_W'(sum);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.acc <= '0;
            st_q.en  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o = st_q.en;

    AST_ACC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.acc < PCT_W'(PCT_FULL)); // R9
    AST_PASS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        pass_i <= PCT_W'(PCT_FULL)); // R9
    AST_FULL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_i == PCT_W'(PCT_FULL)) |=> en_o); // R8
    AST_FULL_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_i == '0) |=> !en_o); // R9
    AST_NO_DOUBLE_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_i >= PCT_W'(50) && $stable(pass_i) && !en_o) |=> en_o); // R11
endmodule

// File: rtl/thr_skip_top.sv
module thr_skip_top
    import thr_pkg::*;
#(
    parameter  int NTHERM = 2,
    parameter  int TEMP_W = 8,
    localparam int NREQ   = NTHERM + 1,
    localparam int IDXW   = $clog2(NREQ)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NTHERM*TEMP_W-1:0] temp_i,
    input  logic                     oc_alarm_i,
    input  logic                     cfg_we_i,
    input  logic [IDXW-1:0]          cfg_idx_i,
    input  logic [PCT_W-1:0]         cfg_prio_i,
    input  logic [PCT_W-1:0]         cfg_cpu_pct_i,
    input  logic [LVL_W-1:0]         cfg_gpu_lvl_i,
    input  logic [TEMP_W-1:0]        cfg_thr_i,
    output logic                     sel_valid_o,
    output logic [IDXW-1:0]          sel_idx_o,
    output logic [PCT_W-1:0]         sel_cpu_pct_o,
    output logic [LVL_W-1:0]         sel_gpu_lvl_o,
    output logic                     cpu_clk_en_o,
    output logic                     gpu_clk_en_o
);
    localparam int NCH = 2;

    thr_cfg_t [NREQ-1:0]           cfg;
    logic [NTHERM-1:0][TEMP_W-1:0] thr;
    logic [NREQ-1:0]               raised;
    logic [NCH-1:0][PCT_W-1:0]     pass;
    logic [NCH-1:0]                en;

    thr_cfg_regs #(.NREQ(NREQ), .NTHERM(NTHERM), .TEMP_W(TEMP_W), .IDXW(IDXW)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (cfg_we_i),
        .idx_i  (cfg_idx_i),
        .prio_i (cfg_prio_i),
        .pct_i  (cfg_cpu_pct_i),
        .lvl_i  (cfg_gpu_lvl_i),
        .thr_i  (cfg_thr_i),
        .cfg_o  (cfg),
        .thr_o  (thr)
    );

    thr_req_gen #(.NTHERM(NTHERM), .TEMP_W(TEMP_W), .NREQ(NREQ)) u_req (
        .temp_i   (temp_i),
        .thr_i    (thr),
        .oc_i     (oc_alarm_i),
        .raised_o (raised)
    );

    thr_prio_sel #(.NREQ(NREQ), .IDXW(IDXW)) u_sel (
        .clk         (clk),
        .rst_n       (rst_n),
        .raised_i    (raised),
        .cfg_i       (cfg),
        .sel_valid_o (sel_valid_o),
        .sel_idx_o   (sel_idx_o),
        .sel_pct_o   (sel_cpu_pct_o),
        .sel_lvl_o   (sel_gpu_lvl_o)
    );

    assign pass[0] = cpu_pass(sel_cpu_pct_o);
    assign pass[1] = lvl_pass(sel_gpu_lvl_o);

    for (genvar c = 0; c < NCH; c++) begin : g_skip
        thr_pulse_skip u_skip (
            .clk    (clk),
            .rst_n  (rst_n),
            .pass_i (pass[c]),
            .en_o   (en[c])
        );
    end

    assign cpu_clk_en_o = en[0];
    assign gpu_clk_en_o = en[1];
endmodule

// File: tb/tb_thr_skip_top.sv
`timescale 1ns/1ps
module tb_thr_skip_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] temp_i = '0;
    logic        oc_alarm_i = 1'b0;
    logic        cfg_we_i = 1'b0;
    logic [1:0]  cfg_idx_i = '0;
    logic [6:0]  cfg_prio_i = '0;
    logic [6:0]  cfg_cpu_pct_i = '0;
    logic [1:0]  cfg_gpu_lvl_i = '0;
    logic [7:0]  cfg_thr_i = '0;
    logic        sel_valid_o;
    logic [1:0]  sel_idx_o;
    logic [6:0]  sel_cpu_pct_o;
    logic [1:0]  sel_gpu_lvl_o;
    logic        cpu_clk_en_o;
    logic        gpu_clk_en_o;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    thr_skip_top dut (.*);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input int idx, input int prio, input int pct, input int lvl, input int thr);
        cfg_we_i = 1'b1; cfg_idx_i = 2'(idx); cfg_prio_i = 7'(prio);
        cfg_cpu_pct_i = 7'(pct); cfg_gpu_lvl_i = 2'(lvl); cfg_thr_i = 8'(thr);
        @(negedge clk);
        cfg_we_i = 1'b0;
    endtask

    task automatic count_en(input int n, output int c_cpu, output int c_gpu, output int max_low);
        int run;
        c_cpu = 0; c_gpu = 0; max_low = 0; run = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            c_cpu += int'(cpu_clk_en_o);
            c_gpu += int'(gpu_clk_en_o);
            if (!cpu_clk_en_o) run++; else run = 0;
            if (run > max_low) max_low = run;
        end
    endtask

    task automatic chk_sel(input string tag, input int v, input int idx, input int pct, input int lvl);
        chk(int'(sel_valid_o) == v, {tag, " valid"}, int'(sel_valid_o), v);
        if (v != 0) chk(int'(sel_idx_o) == idx, {tag, " idx"}, int'(sel_idx_o), idx);
        chk(int'(sel_cpu_pct_o) == pct, {tag, " pct"}, int'(sel_cpu_pct_o), pct);
        chk(int'(sel_gpu_lvl_o) == lvl, {tag, " lvl"}, int'(sel_gpu_lvl_o), lvl);
    endtask

    task automatic t_reset();
        int c, g, m;
        oc_alarm_i = 1'b1;
        @(negedge clk);
        chk_sel("R1 reset", 0, 0, 0, 0);
        count_en(50, c, g, m);
        chk(c == 50, "R1 cpu enables", c, 50);
        chk(g == 50, "R1 gpu enables", g, 50);
        oc_alarm_i = 1'b0;
    endtask

    task automatic t_thermal();
        int c, g, m;
        cfg_write(0, 80, 50, 1, 100);
        cfg_write(1, 100, 85, 3, 50);
        cfg_write(2, 60, 75, 2, 0);
        temp_i = {8'd50, 8'd100};
        @(negedge clk);
        chk_sel("R3 equal", 0, 0, 0, 0);
        temp_i = {8'd50, 8'd101};
        @(negedge clk);
        chk_sel("R2 R3 above", 1, 0, 50, 1);
        count_en(100, c, g, m);
        chk(c == 50, "R9 cpu 50pct", c, 50);
        chk(g == 50, "R10 gpu lvl1", g, 50);
        chk(m <= 1, "R11 spread", m, 1);
    endtask

    task automatic t_priority();
        int c, g, m;
        temp_i = {8'd51, 8'd101};
        @(negedge clk);
        chk_sel("R6 highest", 1, 1, 85, 3);
        count_en(100, c, g, m);
        chk(c == 15, "R12 cpu after switch", c, 15);
        chk(g == 15, "R10 gpu lvl3", g, 15);
        temp_i = '0; oc_alarm_i = 1'b1;
        @(negedge clk);
        chk_sel("R4 overcurrent", 1, 2, 75, 2);
        count_en(100, c, g, m);
        chk(c == 25, "R12 cpu 75pct", c, 25);
        chk(g == 25, "R10 gpu lvl2", g, 25);
        temp_i = {8'd0, 8'd101};
        @(negedge clk);
        chk_sel("R6 thermal over oc", 1, 0, 50, 1);
    endtask

    task automatic t_tie();
        cfg_write(2, 80, 75, 2, 0);
        @(negedge clk);
        chk_sel("R7 tie", 1, 0, 50, 1);
        cfg_write(0, 0, 50, 1, 100);
        @(negedge clk);
        chk_sel("R5 disabled", 1, 2, 75, 2);
        cfg_write(3, 100, 100, 3, 0);
        @(negedge clk);
        chk_sel("R2 bad index", 1, 2, 75, 2);
        oc_alarm_i = 1'b0;
    endtask

    task automatic t_sat();
        int c, g, m;
        cfg_write(0, 100, 0, 0, 100);
        cfg_write(1, 120, 120, 0, 50);
        temp_i = {8'd51, 8'd101};
        @(negedge clk);
        chk_sel("R5 prio sat tie", 1, 0, 0, 0);
        count_en(100, c, g, m);
        chk(c == 100, "R9 pct0", c, 100);
        cfg_write(0, 10, 0, 0, 100);
        @(negedge clk);
        chk_sel("R5 pct sat", 1, 1, 100, 0);
        count_en(100, c, g, m);
        chk(c == 0, "R9 pct100", c, 0);
        chk(g == 100, "R10 gpu lvl0", g, 100);
    endtask

    task automatic t_none();
        int c, g, m;
        temp_i = '0; oc_alarm_i = 1'b0;
        @(negedge clk);
        chk_sel("R8 idle", 0, 0, 0, 0);
        count_en(100, c, g, m);
        chk(c == 100, "R8 cpu idle", c, 100);
        chk(g == 100, "R8 gpu idle", g, 100);
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_thermal();
        t_priority();
        t_tie();
        t_sat();
        t_none();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule